// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR SDRAM channel. It takes the memory from the moment reset is released to an idle, programmed state. It holds the clock enable low while the clock settles. It then issues the fixed bring-up command sequence on the chip-select, row-strobe, column-strobe and write-enable pins, together with the address and bank-address buses. Every gap between commands is a count of clock cycles, derived from timing parameters given in picoseconds and from the clock period.

One pulse on `start` begins the sequence. On that same edge the block captures the mode settings: burst length, burst ordering, read latency and output drive strength. When all programming is finished and the DLL lock window has passed, `done` rises and stays high. From then on the block drives only idle commands, so that the normal traffic logic can take over the bus. The sequence runs once per reset.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted and while idle before a start, `cke` is 0, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `ba` and `addr` are 0, and `done` is 0.
- R2: After the edge that samples `start`, `cke` stays 0 for exactly STABLE_CYC = ceil(STABLE_PS/TCK_PS) cycles. It then goes to 1 and stays 1 until reset.
- R3: The sequence issues exactly seven commands, each lasting one cycle, in this order: precharge-all (4'b0010 with addr[8]=1), extended mode write (4'b0000, ba=1), mode write with DLL reset (4'b0000, ba=0), precharge-all, refresh (4'b0001), refresh, and final mode write (4'b0000, ba=0).
- R4: The first command follows the rise of `cke` by CKE_NOP_CYC cycles. The next command follows a precharge-all by ceil(TRP_PS/TCK_PS) cycles, a refresh by ceil(TRFC_PS/TCK_PS) cycles, and any mode write by TMRD_CYC cycles.
- R5: The extended mode write enables the DLL with addr[0]=0. It carries cfg_drive[0] on addr[1] and cfg_drive[1] on addr[6]. All other address bits are 0.
- R6: Both mode writes carry the burst length on addr[2:0], the interleave bit on addr[3] and the read latency on addr[6:4], with addr[7]=0, addr[11:9]=0 and ba=0. addr[8] is 1 on the first mode write and 0 on the final one.
- R7: `done` rises on the edge max(T_fin + TMRD_CYC, T_rst + DLL_LOCK_CYC). Here T_fin is the cycle of the final mode write and T_rst is the cycle of the DLL-reset mode write.
- R8: Once high, `done` stays high until reset. After it rises, the pins show only NOP and a further `start` has no effect.
- R9: A `start` pulse during the sequence has no effect. The mode written is the configuration sampled with the first `start`, even if the configuration inputs change later.
- R10: Every cycle that carries none of the seven commands drives NOP with `ba` and `addr` at 0. No command other than NOP appears while `cke` is 0.
- R11: Reset asserted in the middle of the sequence returns `cke`, the pins and `done` to the R1 state at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, also the memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin bring-up |
| cfg_burst_len | input | 3 | Burst length code for the mode register |
| cfg_interleave | input | 1 | Burst ordering: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | Read latency code for the mode register |
| cfg_drive | input | 2 | Output drive strength bits for the extended register |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Multiplexed address |
| done | output | 1 | Sticky flag: memory programmed and DLL settled |

## Verification
Some properties are checked on every cycle: `cke` never falls and `done` never clears outside reset. No command other than NOP appears while `cke` is low, and no command lasts more than one cycle. Every mode write keeps its reserved bits low, `done` never rises before the lock counter reports the window complete, and only NOP appears after `done`. Other properties can only be shown by the bench's scenarios. These are the exact cycle of each command and of `done` relative to `start`, the address fields that carry the randomly drawn configurations, and the fact that a repeated `start`, a configuration change during the run, or a reset mid-sequence is ignored or aborts as required.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_STABLE,
    ST_CKE,
    ST_PREA1,
    ST_EMRS,
    ST_MRS_RST,
    ST_PREA2,
    ST_REF1,
    ST_REF2,
    ST_MRS_FIN,
    ST_DONE
  } init_step_e;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_PREA,
    OP_REF,
    OP_EMRS,
    OP_MRS_RST,
    OP_MRS_FIN
  } init_op_e;

  typedef struct packed {
    logic [2:0] burst_len;
    logic       interleave;
    logic [2:0] cas_lat;
    logic [1:0] drive;
  } mode_cfg_t;

  // ceiling of ps / tck, never below one cycle
  function automatic int unsigned ps_to_cyc(int unsigned ps, int unsigned tck);
    int unsigned c;
    c = (ps + tck - 1) / tck;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R4
  timer_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
  parameter int unsigned LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic lock_ok
);

  if (LOCK_CYC <= 1) begin : g_short
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   armed_q <= 1'b0;
      else if (arm) armed_q <= 1'b1;
    end
    assign lock_ok = armed_q;
  end else begin : g_count
    localparam int unsigned LW = $clog2(LOCK_CYC);
    localparam logic [LW-1:0] LAST = LW'(LOCK_CYC - 1);
    logic          armed_q;
    logic [LW-1:0] cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (arm) begin
        armed_q <= 1'b1;
        cnt_q   <= LW'(1);
      end else if (armed_q && cnt_q != LAST) begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
    assign lock_ok = armed_q && (cnt_q == LAST);
  end

  // R7
  lock_ok_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok |=> lock_ok);

endmodule

// File: rtl/ddr_cmd_encode.sv
module ddr_cmd_encode
  import ddr_init_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BA_W   = 2
) (
  input  init_op_e          op,
  input  mode_cfg_t         cfg,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned AP_BIT  = 8;
  localparam int unsigned DLL_BIT = 8;

  always_comb begin
    cs_n  = 1'b0;
    ras_n = 1'b1;
    cas_n = 1'b1;
    we_n  = 1'b1;
    ba    = '0;
    addr  = '0;
    unique case (op)
      OP_PREA: begin
        ras_n        = 1'b0;
        we_n         = 1'b0;
        addr[AP_BIT] = 1'b1;
      end
      OP_REF: begin
        ras_n = 1'b0;
        cas_n = 1'b0;
      end
      OP_EMRS: begin
        {ras_n, cas_n, we_n} = 3'b000;
        ba[0]   = 1'b1;
        addr[0] = 1'b0;
        addr[1] = cfg.drive[0];
        addr[6] = cfg.drive[1];
      end
      OP_MRS_RST, OP_MRS_FIN: begin
        {ras_n, cas_n, we_n} = 3'b000;
        addr[2:0]     = cfg.burst_len;
        addr[3]       = cfg.interleave;
        addr[6:4]     = cfg.cas_lat;
        addr[DLL_BIT] = (op == OP_MRS_RST);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned TCK_PS       = 5000,
  parameter int unsigned STABLE_PS    = 200_000_000,
  parameter int unsigned TRP_PS       = 20_000,
  parameter int unsigned TRFC_PS      = 70_000,
  parameter int unsigned TMRD_CYC     = 2,
  parameter int unsigned CKE_NOP_CYC  = 1,
  parameter int unsigned DLL_LOCK_CYC = 200,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned BA_W         = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_interleave,
  input  logic [2:0]        cfg_cas_lat,
  input  logic [1:0]        cfg_drive,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam int unsigned STABLE_CYC = ps_to_cyc(STABLE_PS, TCK_PS);
  localparam int unsigned TRP_CYC    = ps_to_cyc(TRP_PS, TCK_PS);
  localparam int unsigned TRFC_CYC   = ps_to_cyc(TRFC_PS, TCK_PS);
  localparam int unsigned MRD_CYC    = (TMRD_CYC == 0) ? 1 : TMRD_CYC;
  localparam int unsigned CKN_CYC    = (CKE_NOP_CYC == 0) ? 1 : CKE_NOP_CYC;
  localparam int unsigned MAX_GAP    =
    max2(max2(STABLE_CYC, TRP_CYC), max2(max2(TRFC_CYC, MRD_CYC), CKN_CYC));
  localparam int unsigned TW         = $clog2(MAX_GAP + 1);

  init_step_e step_q, step_d;
  logic       first_q, first_d;
  mode_cfg_t  cfg_q, cfg_d;
  logic       done_q, done_d;
  logic       tmr_load, tmr_expired, lock_ok;
  logic [TW-1:0] tmr_val;
  init_op_e   op;

  function automatic init_step_e follow(init_step_e s);
    unique case (s)
      ST_CKE:     return ST_PREA1;
      ST_PREA1:   return ST_EMRS;
      ST_EMRS:    return ST_MRS_RST;
      ST_MRS_RST: return ST_PREA2;
      ST_PREA2:   return ST_REF1;
      ST_REF1:    return ST_REF2;
      ST_REF2:    return ST_MRS_FIN;
      default:    return ST_DONE;
    endcase
  endfunction

  function automatic int unsigned gap_of(init_step_e s);
    unique case (s)
      ST_CKE:                        return CKN_CYC;
      ST_PREA1, ST_PREA2:            return TRP_CYC;
      ST_REF1, ST_REF2:              return TRFC_CYC;
      ST_EMRS, ST_MRS_RST, ST_MRS_FIN: return MRD_CYC;
      default:                       return 1;
    endcase
  endfunction

  function automatic init_op_e op_of(init_step_e s);
    unique case (s)
      ST_PREA1, ST_PREA2: return OP_PREA;
      ST_REF1, ST_REF2:   return OP_REF;
      ST_EMRS:            return OP_EMRS;
      ST_MRS_RST:         return OP_MRS_RST;
      ST_MRS_FIN:         return OP_MRS_FIN;
      default:            return OP_NOP;
    endcase
  endfunction

  always_comb begin
    step_d   = step_q;
    first_d  = 1'b0;
    cfg_d    = cfg_q;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (step_q)
      ST_IDLE: begin
        if (start) begin
          cfg_d    = '{burst_len: cfg_burst_len, interleave: cfg_interleave,
                       cas_lat: cfg_cas_lat, drive: cfg_drive};
          step_d   = ST_STABLE;
          tmr_load = 1'b1;
          tmr_val  = TW'(STABLE_CYC - 1);
        end
      end
      ST_STABLE: begin
        if (tmr_expired) begin
          step_d   = ST_CKE;
          first_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(CKN_CYC - 1);
        end
      end
      ST_MRS_FIN: begin
        if (tmr_expired && lock_ok) begin
          step_d = ST_DONE;
          done_d = 1'b1;
        end
      end
      ST_DONE: ;
      default: begin
        if (tmr_expired) begin
          step_d   = follow(step_q);
          first_d  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(gap_of(follow(step_q)) - 1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= ST_IDLE;
      first_q <= 1'b0;
      cfg_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      step_q  <= step_d;
      first_q <= first_d;
      cfg_q   <= cfg_d;
      done_q  <= done_d;
    end
  end

  ddr_init_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  ddr_init_lock #(.LOCK_CYC(DLL_LOCK_CYC)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (step_q == ST_MRS_RST && first_q),
    .lock_ok (lock_ok)
  );

  assign op = first_q ? op_of(step_q) : OP_NOP;

  ddr_cmd_encode #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .op    (op),
    .cfg   (cfg_q),
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .ba    (ba),
    .addr  (addr)
  );

  assign cke  = (step_q != ST_IDLE) && (step_q != ST_STABLE);
  assign done = done_q;

  // R2
  cke_stays_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  // R8
  nop_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cs_n && ras_n && cas_n && we_n));
  // R7
  done_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lock_ok);
  // R10
  no_cmd_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!cs_n && ras_n && cas_n && we_n));
  // R3
  single_cycle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ras_n && cas_n && we_n) |=> (ras_n && cas_n && we_n));
  // R6
  mode_reserved_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !cas_n && !we_n && !ba[0]) |->
      (!ba[BA_W-1] && !addr[7] && addr[ADDR_W-1:9] == '0));

endmodule

// File: tb/test_ddr_init_seq.sv
module test_ddr_init_seq;

  localparam int unsigned TCK_PS = 10_000;
  localparam int unsigned STB_PS = 1_000_000;
  localparam int unsigned RP_PS  = 20_000;
  localparam int unsigned RFC_PS = 70_000;
  localparam int unsigned MRD    = 2;
  localparam int unsigned CKN    = 1;
  localparam int unsigned LOCK   = 200;

  function automatic int unsigned to_cyc(int unsigned ps);
    int unsigned c;
    c = (ps + TCK_PS - 1) / TCK_PS;
    return (c == 0) ? 1 : c;
  endfunction

  localparam int unsigned ST  = to_cyc(STB_PS);
  localparam int unsigned RP  = to_cyc(RP_PS);
  localparam int unsigned RFC = to_cyc(RFC_PS);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [2:0] bl = '0, cl = '0;
  logic bt = 1'b0;
  logic [1:0] drv = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0] ba;
  logic [11:0] addr;

  ddr_init_seq #(
    .TCK_PS(TCK_PS), .STABLE_PS(STB_PS), .TRP_PS(RP_PS), .TRFC_PS(RFC_PS),
    .TMRD_CYC(MRD), .CKE_NOP_CYC(CKN), .DLL_LOCK_CYC(LOCK)
  ) i_ddr_init_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_burst_len(bl), .cfg_interleave(bt), .cfg_cas_lat(cl), .cfg_drive(drv),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .done(done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // recorder
  bit rec = 0, cke_seen, cke_fell, done_seen;
  int cke_at, done_at, ev_n, nop_bad;
  int ev_cyc[16];
  logic [3:0] ev_cmd[16];
  logic [1:0] ev_ba[16];
  logic [11:0] ev_addr[16];

  always @(negedge clk) if (rec) begin
    if (cke && !cke_seen) begin cke_seen = 1; cke_at = cyc; end
    if (!cke && cke_seen) cke_fell = 1;
    if (done && !done_seen) begin done_seen = 1; done_at = cyc; end
    if (cs_n || !(ras_n && cas_n && we_n)) begin
      if (ev_n < 16) begin
        ev_cyc[ev_n] = cyc; ev_cmd[ev_n] = {cs_n, ras_n, cas_n, we_n};
        ev_ba[ev_n] = ba; ev_addr[ev_n] = addr;
      end
      ev_n++;
    end else if (ba != 0 || addr != 0) nop_bad++;
  end

  // expected model
  function automatic int unsigned exp_off(int i);
    int unsigned t;
    int unsigned gaps[6] = '{RP, MRD, MRD, RP, RFC, RFC};
    t = ST + CKN;
    for (int k = 0; k < i; k++) t += gaps[k];
    return t;
  endfunction

  function automatic int unsigned exp_done();
    int unsigned a, b;
    a = exp_off(6) + MRD;
    b = exp_off(2) + LOCK;
    return (a > b) ? a : b;
  endfunction

  function automatic logic [3:0] exp_cmd(int i);
    case (i)
      0, 3: return 4'b0010;
      4, 5: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [11:0] mode_word(logic [2:0] b, logic t, logic [2:0] c, logic dll);
    return {3'b000, dll, 1'b0, c, t, b};
  endfunction

  function automatic logic [11:0] exp_addr(int i, logic [2:0] b, logic t, logic [2:0] c, logic [1:0] d);
    case (i)
      0, 3: return 12'h100;
      1: return (12'(d[1]) << 6) | (12'(d[0]) << 1);
      2: return mode_word(b, t, c, 1'b1);
      6: return mode_word(b, t, c, 1'b0);
      default: return 12'h000;
    endcase
  endfunction

  task automatic chk_idle(input string req);
    chk({req, " cke"}, cke, 0);
    chk({req, " pins"}, {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk({req, " ba/addr"}, {ba, addr}, 0);
    chk({req, " done"}, done, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R1 idle");
  endtask

  task automatic pulse_start();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic run_once(input logic [2:0] b, input logic t, input logic [2:0] c,
                          input logic [1:0] d, input bit poke);
    int n0;
    do_reset();
    cke_seen = 0; cke_fell = 0; done_seen = 0; cke_at = -1; done_at = -1;
    ev_n = 0; nop_bad = 0; rec = 1;
    bl = b; bt = t; cl = c; drv = d;
    @(negedge clk);
    n0 = cyc + 1;
    pulse_start();
    if (poke) begin
      // R9: configuration changes and repeated starts after the first are ignored
      bl = ~b; bt = ~t; cl = ~c; drv = ~d;
      repeat (40) @(negedge clk);
      pulse_start();
      repeat (70) @(negedge clk);
      pulse_start();
    end
    while (cyc < n0 + int'(exp_done()) + 4) @(negedge clk);
    pulse_start(); // R8: start after done
    repeat (20) @(negedge clk);
    rec = 0;
    chk("R2 cke rise cycle", cke_at - n0, ST);
    chk("R2 cke never falls", cke_fell, 0);
    chk("R3 command count", ev_n, 7);
    for (int i = 0; i < 7 && i < ev_n; i++) begin
      chk($sformatf("R4 cmd %0d cycle", i), ev_cyc[i] - n0, exp_off(i));
      chk($sformatf("R3 cmd %0d code", i), ev_cmd[i], exp_cmd(i));
      chk($sformatf("R3 cmd %0d bank", i), ev_ba[i], (i == 1) ? 1 : 0);
      chk($sformatf("%s cmd %0d addr", (i == 1) ? "R5" : "R6", i),
          ev_addr[i], exp_addr(i, b, t, c, d));
    end
    chk("R7 done cycle", done_at - n0, exp_done());
    chk("R8 done held", done, 1);
    chk("R10 clean NOP cycles", nop_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // directed corners
    run_once(3'b010, 1'b0, 3'b011, 2'b00, 1'b0);
    run_once(3'b111, 1'b1, 3'b100, 2'b11, 1'b1);
    // R11: reset mid-sequence
    begin
      int n0;
      do_reset();
      @(negedge clk); n0 = cyc + 1; pulse_start();
      while (cyc < n0 + int'(ST + CKN) + 3) @(negedge clk);
      chk("R11 cke high before abort", cke, 1);
      rst_n = 1'b0;
      #1;
      chk("R11 cke after abort", cke, 0);
      chk("R11 done after abort", done, 0);
      chk("R11 pins after abort", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
      @(negedge clk);
    end
    // random configurations
    for (int r = 0; r < 5; r++) begin
      run_once(3'($urandom), 1'($urandom), 3'($urandom), 2'($urandom), 1'($urandom));
    end
    summary();
  end

  initial begin
    repeat (150_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule